// File: doc/BRIEF.md
# Modulo Timer with Prescaler

This block is a 16-bit up-counter with a programmable end value. It advances either on a divided copy of the bus clock or on rising edges of an external clock pin, which is synchronised into the bus clock domain. When the counter arrives at the programmed modulo value, it raises an overflow flag. On the next advance it restarts from zero.

Four channel event strobes come from capture or compare logic outside the block, and each one sets its own flag. Every flag, the overflow flag included, has its own interrupt enable. All the enabled flags are combined into one registered interrupt request.

Software reaches the block through a small register port with a registered read path. While the low-power wait input is high, the counter and the interrupt logic keep working, but all register accesses are ignored.

Top module: `modtimer_top`

## Requirements
- R1: Reset is synchronous and active high. After reset the counter, all five flags, all enables, the read data and `irq` are 0, the modulo register reads FFFFh, and the clock select field reads 000.
- R2: Clock select codes 0 to 6 advance the counter once every 2^code bus cycles, paced by a free-running divider that restarts at reset. With code 0 the counter advances on every cycle.
- R3: Clock select code 7 advances the counter once for each rising edge of `ext_clk`. The counter register shows the new value from the third rising bus clock edge after the pin rises.
- R4: On each advance the counter becomes 0000h if it equals the modulo value, and counter+1 otherwise. A counter above the modulo value therefore runs on through FFFFh and then 0000h.
- R5: The overflow flag (status bit 0) is set by every advance whose new counter value equals the modulo value.
- R6: In any cycle where `chan_evt[i]` is high, the channel flag in status bit i+1 is set.
- R7: Writing the status register with a 0 in a flag's bit clears that flag, and a 1 leaves it as it is. If a set event arrives in the same cycle as the clear, the flag stays set.
- R8: `irq` is registered. After each clock edge it equals the OR, over the five flags, of flag AND enable, using the flag and enable values stored at that same edge.
- R9: While `wait_mode` is 1, register writes have no effect and `reg_rdata` holds its value. The counter, the flags and `irq` keep working as usual.
- R10: The register map has four addresses. Address 0 is control: bits [2:0] clock select, bit 3 overflow enable, bits [7:4] channel enables. Address 1 is status: bit 0 overflow, bits [4:1] channels 0 to 3. Address 2 is the modulo value. Address 3 is the counter, which is read-only. A read with `reg_rd` high loads `reg_rdata` at the clock edge with the value the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| ext_clk | input | 1 | External count clock, at most half the bus clock rate |
| chan_evt | input | 4 | Per-channel capture/compare event strobes |
| wait_mode | input | 1 | Low-power wait indication |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bound checker checks these rules on every cycle:
- the counter only moves on an advance, and then either steps by one or restarts at the modulo value;
- the overflow flag never rises without an advance that lands on the modulo value;
- a channel strobe always leaves its flag set, even when a clear arrives in the same cycle;
- `irq` always matches the enabled flags;
- no configuration changes during wait.

Some behaviour can only be shown by the bench scenarios, which compare the ports against a behavioural model on every clock:
- the division ratio of each clock select code;
- the three-cycle latency of the synchronised pin;
- the outcome of selective clears;
- the read data held during wait.

// File: rtl/modtimer_pkg.sv
package modtimer_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_MOD  = 2'd2,
    RA_CNT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/modtimer_presc.sv
module modtimer_presc #(
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            ext_clk,
  output logic            tick
);
  localparam int NCODE = 2 ** PS_W;
  localparam int DIV_W = NCODE - 2;

  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] sync_q;
  logic [NCODE-1:0]     tap;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sync_q <= '0;
    end else begin
      div_q  <= div_q + DIV_W'(1);
      sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
    end
  end

  // one tap per division code; the last code is the pin edge
  for (genvar k = 0; k < NCODE; k++) begin : g_tap
    if (k == 0) begin : g_div1
      assign tap[k] = 1'b1;
    end else if (k == NCODE - 1) begin : g_ext
      assign tap[k] = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    end else begin : g_divn
      assign tap[k] = &div_q[k-1:0];
    end
  end

  assign tick = tap[ps_sel];
endmodule

// File: rtl/modtimer_counter.sv
module modtimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] mod_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx  = (cnt_q == mod_val) ? '0 : cnt_q + CNT_W'(1);
  assign ovf_evt = tick && (cnt_nx == mod_val);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/modtimer_flags.sv
module modtimer_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] keep_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flag_q,
  output logic         req_o
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flag_d[i] = set_i[i] | (flag_q[i] & ~(clr_i & ~keep_i[i]));
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end

  assign req_o = |(flag_d & en_i);
endmodule

// File: rtl/modtimer_top.sv
module modtimer_top #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_clk,
  input  logic [NCH-1:0]   chan_evt,
  input  logic             wait_mode,
  output logic             irq
);
  import modtimer_pkg::*;

  localparam int NFLG   = NCH + 1;
  localparam int CTRL_W = PS_W + 1 + NCH;

  logic [PS_W-1:0]  ps_q;
  logic [NFLG-1:0]  ien_q, ien_d;
  logic [CNT_W-1:0] mod_q, cnt_q;
  logic [NFLG-1:0]  flag_q;
  logic             tick_w, ovf_evt, req_w, irq_q;
  logic             wr_ok, rd_ok, ctrl_wr, stat_wr;
  logic [CNT_W-1:0] rd_mux;

  assign wr_ok   = reg_wr & ~wait_mode;
  assign rd_ok   = reg_rd & ~wait_mode;
  assign ctrl_wr = wr_ok && (reg_addr == RA_CTRL);
  assign stat_wr = wr_ok && (reg_addr == RA_STAT);
  assign ien_d   = ctrl_wr ? reg_wdata[CTRL_W-1:PS_W] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q  <= '0;
      ien_q <= '0;
      mod_q <= '1;
    end else begin
      ien_q <= ien_d;
      if (ctrl_wr) ps_q <= reg_wdata[PS_W-1:0];
      if (wr_ok && reg_addr == RA_MOD) mod_q <= reg_wdata;
    end
  end

  modtimer_presc #(.PS_W(PS_W), .SYNC_STAGES(2)) u_presc (
    .clk(clk), .rst(rst), .ps_sel(ps_q), .ext_clk(ext_clk), .tick(tick_w)
  );

  modtimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .mod_val(mod_q),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt)
  );

  modtimer_flags #(.N(NFLG)) u_flags (
    .clk(clk), .rst(rst), .set_i({chan_evt, ovf_evt}), .clr_i(stat_wr),
    .keep_i(reg_wdata[NFLG-1:0]), .en_i(ien_d), .flag_q(flag_q), .req_o(req_w)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL: rd_mux[CTRL_W-1:0] = {ien_q, ps_q};
      RA_STAT: rd_mux[NFLG-1:0]   = flag_q;
      RA_MOD:  rd_mux             = mod_q;
      default: rd_mux             = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= req_w;
      if (rd_ok) reg_rdata <= rd_mux;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/modtimer_chk.sv
module modtimer_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_val,
  input logic [NCH:0]     flags,
  input logic [NCH:0]     ien,
  input logic [PS_W-1:0]  ps,
  input logic [NCH-1:0]   chan_evt,
  input logic             irq,
  input logic             wait_mode,
  input logic             wr_en
);
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    tick && cnt == mod_val |=> cnt == '0);

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    tick && cnt != mod_val |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(tick) && (cnt == mod_val || mod_val != $past(mod_val)));

  p_chan_set_r6: assert property (@(posedge clk) disable iff (rst)
    chan_evt != '0 |=> (flags[NCH:1] & $past(chan_evt)) == $past(chan_evt));

  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & ien));

  p_wait_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    wait_mode && wr_en |=> $stable(ps) && $stable(ien) && $stable(mod_val));
endmodule

bind modtimer_top modtimer_chk #(.CNT_W(CNT_W), .NCH(NCH), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_w), .cnt(cnt_q), .mod_val(mod_q),
  .flags(flag_q), .ien(ien_q), .ps(ps_q), .chan_evt(chan_evt), .irq(irq),
  .wait_mode(wait_mode), .wr_en(reg_wr)
);

// File: tb/tb_modtimer_top.sv
module tb_modtimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        ext_clk = 1'b0;
  logic [3:0]  chan_evt = 4'h0;
  logic        wait_mode = 1'b0;
  logic        irq;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  modtimer_top dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .chan_evt(chan_evt), .wait_mode(wait_mode), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_cnt, m_mod, e_rdata, rv;
  logic [2:0]  m_ps;
  logic        m_oie, m_of, e_irq, s1, s2, s3, tk, oev;
  logic [3:0]  m_cie, m_cf;
  int          m_div;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_mod = 16'hFFFF; m_ps = 0; m_oie = 0; m_cie = 0;
      m_of = 0; m_cf = 0; s1 = 0; s2 = 0; s3 = 0; m_div = 0;
      e_rdata = 0; e_irq = 0;
    end else begin
      if (m_ps == 3'd7) tk = s2 && !s3;
      else tk = ((m_div % (1 << m_ps)) == (1 << m_ps) - 1);
      s3 = s2; s2 = s1; s1 = ext_clk;
      m_div = (m_div + 1) % 64;
      case (reg_addr)
        2'd0: rv = {8'h0, m_cie, m_oie, m_ps};
        2'd1: rv = {11'h0, m_cf, m_of};
        2'd2: rv = m_mod;
        default: rv = m_cnt;
      endcase
      if (reg_rd && !wait_mode) e_rdata = rv;
      oev = 0;
      if (tk) begin
        m_cnt = (m_cnt == m_mod) ? 16'h0 : m_cnt + 16'h1;
        oev = (m_cnt == m_mod);
      end
      if (reg_wr && !wait_mode) begin
        if (reg_addr == 2'd1) begin
          if (!reg_wdata[0]) m_of = 0;
          m_cf = m_cf & reg_wdata[4:1];
        end
      end
      if (oev) m_of = 1;
      m_cf = m_cf | chan_evt;
      if (reg_wr && !wait_mode) begin
        if (reg_addr == 2'd0) begin
          m_ps = reg_wdata[2:0]; m_oie = reg_wdata[3]; m_cie = reg_wdata[7:4];
        end else if (reg_addr == 2'd2) m_mod = reg_wdata;
      end
      e_irq = (m_of && m_oie) || ((m_cf & m_cie) != 0);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (reg_rdata !== e_rdata || irq !== e_irq) begin
        n_bad++;
        $display("FAIL %s t=%0t rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, $time, reg_rdata, irq, e_rdata, e_irq);
      end
    end
  end

  task automatic cyc(input logic w, input logic r, input logic [1:0] a,
                     input logic [15:0] d, input logic [3:0] ev);
    @(posedge clk); #1;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; chan_evt = ev;
  endtask

  task automatic rd_run(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, a, 16'h0, 4'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset values
    cur_req = "R1";
    rd_run(2'd0, 2); rd_run(2'd1, 2); rd_run(2'd2, 2); rd_run(2'd3, 1);
    // R2 R4 divide by one, reload at modulo
    cur_req = "R2/R4";
    rd_run(2'd3, 10);
    cyc(1, 0, 2'd2, 16'd10, 4'h0);
    rd_run(2'd3, 30);
    // R5 R8 overflow flag and its interrupt
    cur_req = "R5/R8";
    cyc(1, 0, 2'd2, 16'd4, 4'h0);
    cyc(1, 0, 2'd0, 16'h000B, 4'h0);
    rd_run(2'd1, 60);
    cyc(1, 0, 2'd1, 16'h0000, 4'h0);
    rd_run(2'd1, 3);
    // R2 each division code
    cur_req = "R2";
    cyc(1, 0, 2'd2, 16'hFFFF, 4'h0);
    for (int c = 1; c < 7; c++) begin
      cyc(1, 0, 2'd0, 16'(c), 4'h0);
      rd_run(2'd3, 140);
    end
    // R3 external pin clock
    cur_req = "R3";
    cyc(1, 0, 2'd0, 16'h0007, 4'h0);
    for (int i = 0; i < 72; i++) begin
      cyc(0, 1, 2'd3, 16'h0, 4'h0);
      ext_clk = ((i / 3) % 2) == 1;
    end
    ext_clk = 0;
    rd_run(2'd3, 6);
    // R6 R7 channel flags, selective clear, set beats clear
    cur_req = "R6/R7";
    cyc(1, 0, 2'd0, 16'h0057, 4'h0);
    cyc(1, 0, 2'd1, 16'h0000, 4'h0);
    cyc(0, 1, 2'd1, 16'h0, 4'b0010);
    rd_run(2'd1, 2);
    cyc(0, 1, 2'd1, 16'h0, 4'b0100);
    rd_run(2'd1, 2);
    cyc(1, 0, 2'd1, 16'hFFF7, 4'h0);
    rd_run(2'd1, 2);
    cyc(1, 0, 2'd1, 16'h0000, 4'b0001);
    rd_run(2'd1, 2);
    cyc(1, 0, 2'd1, 16'h0000, 4'h0);
    rd_run(2'd1, 2);
    // R9 wait: accesses ignored, counting and interrupts continue
    cur_req = "R9";
    cyc(1, 0, 2'd0, 16'h00F0, 4'h0);
    rd_run(2'd3, 2);
    wait_mode = 1;
    cyc(1, 1, 2'd0, 16'h0003, 4'h0);
    cyc(1, 1, 2'd2, 16'h0005, 4'h0);
    cyc(0, 1, 2'd1, 16'h0, 4'b1000);
    rd_run(2'd3, 8);
    wait_mode = 0;
    rd_run(2'd0, 2); rd_run(2'd2, 2); rd_run(2'd1, 2); rd_run(2'd3, 3);
    // R10 counter read-only, address map
    cur_req = "R10";
    cyc(1, 0, 2'd3, 16'h1234, 4'h0);
    rd_run(2'd3, 3); rd_run(2'd0, 2); rd_run(2'd1, 2); rd_run(2'd2, 2);
    // R4 counter above a lowered modulo runs on through FFFFh
    cur_req = "R4";
    cyc(1, 0, 2'd2, 16'd2, 4'h0);
    rd_run(2'd3, 8);
    rd_run(2'd1, 2);
    cyc(0, 0, 2'd0, 16'h0, 4'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule